// File: doc/BRIEF.md
# UART Modem Handshake Control and Status

This block carries the modem-handshake side of a UART. A five-bit control register sets the four active-low handshake outputs (DTR#, RTS#, OUT1#, OUT2#) and a loopback switch. A status register shows the current, active-high levels of the four modem inputs: CTS#, DSR#, RI# and DCD#. It also holds four sticky change flags. The flags raise an interrupt request when the external enable is set.

Each modem input passes through a two-flop synchroniser before it is compared with its value on the previous cycle. Software clears a change flag by writing a one to that flag's position. In loopback, the external pins are parked high and the external inputs are ignored. The status levels then come from the control bits, so software can test the handshake path without a cable.

Top module: `uart_modem_ctl`

## Requirements
- R1: While reset is held, the control register reads 00h and the status register reads 00h. All four handshake outputs are 1 and irq_o is 0.
- R2: A write at offset 4 stores wdata_i[4:0] as control bits: bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2, bit 4 loopback. A read at offset 4 returns these bits, with bits 7:5 reading 0.
- R3: With loopback off, each output is the inverse of its control bit: dtr_no = ~bit0, rts_no = ~bit1, out1_no = ~bit2, out2_no = ~bit3.
- R4: A read at offset 6 returns the levels DCD, RI, DSR, CTS in bits 7, 6, 5, 4. Each level is the complement of its pin. The level shows the pin value applied before the second rising edge that follows.
- R5: The change flags sit in bits 0 (CTS), 1 (DSR), 2 (RI) and 3 (DCD). A flag is set one edge after its status level changes and stays at 1 until it is cleared.
- R6: A write at offset 6 clears the flags at the positions where wdata_i[3:0] is 1. Flags at positions written 0, and status bits 7:4, are not affected.
- R7: When a flag's clear and a change of its level fall on the same edge, the flag stays at 1.
- R8: irq_o is 1 exactly when msi_en_i is 1 and at least one change flag is 1.
- R9: With loopback on, all four outputs are 1 and the external inputs are ignored. The status levels are DCD = OUT2, RI = OUT1, DSR = DTR and CTS = RTS. Any level difference this causes, including the one at entering or leaving loopback, sets that flag.
- R10: A read at any offset other than 4 and 6 returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for the register port |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| msi_en_i | input | 1 | Modem-status interrupt enable from the interrupt-enable register |
| cts_ni | input | 1 | Clear-to-send, active low, asynchronous |
| dsr_ni | input | 1 | Data-set-ready, active low, asynchronous |
| ri_ni | input | 1 | Ring indicator, active low, asynchronous |
| dcd_ni | input | 1 | Carrier detect, active low, asynchronous |
| dtr_no | output | 1 | Data-terminal-ready, active low |
| rts_no | output | 1 | Request-to-send, active low |
| out1_no | output | 1 | General output 1, active low |
| out2_no | output | 1 | General output 2, active low |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
- A pin change shows in the status levels after the second rising edge.
- The matching flag, and irq_o with it, follows one edge later.
- A control write reaches the outputs, and the loopback levels, right after the edge that takes it. A loopback-induced flag appears one edge after that.

The bench keeps a reference model stepped on the same edges. It drives inputs and reads back at the falling edge, so each comparison sees exactly the registered state due at that point. A directed sequence places a clear on the same edge as a synchronised change.

// File: rtl/uart_mdm_pkg.sv
package uart_mdm_pkg;
  localparam int unsigned NUM_LINES = 4;

  // line index order shared by levels and flags
  localparam int unsigned LN_CTS = 0;
  localparam int unsigned LN_DSR = 1;
  localparam int unsigned LN_RI  = 2;
  localparam int unsigned LN_DCD = 3;

  localparam int unsigned CTL_W = 5;

  typedef struct packed {
    logic loop;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } mcr_t;
endpackage

// File: rtl/uart_mdm_sync.sv
module uart_mdm_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    logic [WIDTH-1:0] src;
    if (s == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = stg_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else         stg_q[s] <= src;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/uart_mdm_ctrl.sv
module uart_mdm_ctrl
  import uart_mdm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  output mcr_t             mcr_o,
  output logic             dtr_no,
  output logic             rts_no,
  output logic             out1_no,
  output logic             out2_no
);
  mcr_t mcr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mcr_q <= '0;
    else if (we_i) mcr_q <= mcr_t'(wdata_i);
  end

  // loopback parks every pin at its idle (high) level
  always_comb begin
    dtr_no  = mcr_q.loop | ~mcr_q.dtr;
    rts_no  = mcr_q.loop | ~mcr_q.rts;
    out1_no = mcr_q.loop | ~mcr_q.out1;
    out2_no = mcr_q.loop | ~mcr_q.out2;
  end

  assign mcr_o = mcr_q;
endmodule

// File: rtl/uart_mdm_status.sv
module uart_mdm_status
  import uart_mdm_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] ext_lvl_i,
  input  mcr_t                 mcr_i,
  input  logic                 clr_we_i,
  input  logic [NUM_LINES-1:0] clr_i,
  output logic [NUM_LINES-1:0] lvl_o,
  output logic [NUM_LINES-1:0] flg_o
);
  logic [NUM_LINES-1:0] loop_lvl, prev_q, flg_q, clr_m, delta;

  always_comb begin
    loop_lvl         = '0;
    loop_lvl[LN_CTS] = mcr_i.rts;
    loop_lvl[LN_DSR] = mcr_i.dtr;
    loop_lvl[LN_RI]  = mcr_i.out1;
    loop_lvl[LN_DCD] = mcr_i.out2;
  end

  assign lvl_o = mcr_i.loop ? loop_lvl : ext_lvl_i;
  assign delta = lvl_o ^ prev_q;
  assign clr_m = clr_we_i ? clr_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      flg_q  <= '0;
    end else begin
      prev_q <= lvl_o;
      // a change beats a clear on the same edge
      flg_q  <= (flg_q & ~clr_m) | delta;
    end
  end

  assign flg_o = flg_q;
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import uart_mdm_pkg::*;
#(
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CTL_OFS     = 4,
  parameter int unsigned STS_OFS     = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              msi_en_i,
  input  logic              cts_ni,
  input  logic              dsr_ni,
  input  logic              ri_ni,
  input  logic              dcd_ni,
  output logic              dtr_no,
  output logic              rts_no,
  output logic              out1_no,
  output logic              out2_no,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_OFS);
  localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_OFS);

  logic                 ctl_sel, sts_sel;
  logic [NUM_LINES-1:0] raw_n, sync_n, msr_lvl, msr_flg;
  mcr_t                 mcr_q;

  assign ctl_sel = (addr_i == CTL_A);
  assign sts_sel = (addr_i == STS_A);

  always_comb begin
    raw_n         = '1;
    raw_n[LN_CTS] = cts_ni;
    raw_n[LN_DSR] = dsr_ni;
    raw_n[LN_RI]  = ri_ni;
    raw_n[LN_DCD] = dcd_ni;
  end

  uart_mdm_sync #(
    .WIDTH  (NUM_LINES),
    .STAGES (SYNC_STAGES),
    .RST_VAL('1)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_n),
    .q_o   (sync_n)
  );

  uart_mdm_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_i & ctl_sel),
    .wdata_i(wdata_i[CTL_W-1:0]),
    .mcr_o  (mcr_q),
    .dtr_no (dtr_no),
    .rts_no (rts_no),
    .out1_no(out1_no),
    .out2_no(out2_no)
  );

  uart_mdm_status u_sts (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ext_lvl_i(~sync_n),
    .mcr_i    (mcr_q),
    .clr_we_i (wr_i & sts_sel),
    .clr_i    (wdata_i[NUM_LINES-1:0]),
    .lvl_o    (msr_lvl),
    .flg_o    (msr_flg)
  );

  always_comb begin
    rdata_o = '0;
    if (ctl_sel)      rdata_o[CTL_W-1:0] = mcr_q;
    else if (sts_sel) rdata_o[2*NUM_LINES-1:0] = {msr_lvl, msr_flg};
  end

  assign irq_o = msi_en_i & (|msr_flg);
endmodule

// File: rtl/uart_modem_ctl_chk.sv
module uart_modem_ctl_chk #(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CTL_OFS = 4,
  parameter int unsigned STS_OFS = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              msi_en_i,
  input logic              dtr_no,
  input logic              rts_no,
  input logic              out1_no,
  input logic              out2_no,
  input logic              irq_o,
  input logic              loop_i,
  input logic [3:0]        lvl_i,
  input logic [3:0]        flg_i
);
  p_pins_idle_loop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_i |-> ({dtr_no, rts_no, out1_no, out2_no} == 4'hf));

  p_dtr_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_W'(CTL_OFS)) |=>
      (dtr_no == ($past(wdata_i[4]) | ~$past(wdata_i[0]))));

  p_irq_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msi_en_i |-> !irq_o);

  p_irq_on_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msi_en_i && flg_i != 4'h0) |-> irq_o);

  for (genvar i = 0; i < 4; i++) begin : g_ln
    // also covers R7: set wins over a same-edge clear
    p_flag_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lvl_i[i] != $past(lvl_i[i])) |=> flg_i[i]);

    p_flag_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flg_i[i] && !(wr_i && addr_i == ADDR_W'(STS_OFS) && wdata_i[i])) |=> flg_i[i]);
  end
endmodule

bind uart_modem_ctl uart_modem_ctl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CTL_OFS(CTL_OFS),
  .STS_OFS(STS_OFS)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .msi_en_i(msi_en_i),
  .dtr_no  (dtr_no),
  .rts_no  (rts_no),
  .out1_no (out1_no),
  .out2_no (out2_no),
  .irq_o   (irq_o),
  .loop_i  (mcr_q.loop),
  .lvl_i   (msr_lvl),
  .flg_i   (msr_flg)
);

// File: tb/sim_uart_modem_ctl.sv
`timescale 1ns/1ps
module sim_uart_modem_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic       msi_en = 1'b0;
  logic [3:0] pin_n = 4'hf;   // idx 0 CTS, 1 DSR, 2 RI, 3 DCD
  logic [7:0] rdata;
  logic       dtr_n, rts_n, o1_n, o2_n, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_modem_ctl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .msi_en_i(msi_en),
    .cts_ni(pin_n[0]), .dsr_ni(pin_n[1]), .ri_ni(pin_n[2]), .dcd_ni(pin_n[3]),
    .dtr_no(dtr_n), .rts_no(rts_n), .out1_no(o1_n), .out2_no(o2_n), .irq_o(irq)
  );

  // reference model, stepped per the requirement timing
  logic [3:0] m_d1, m_d2, m_prev, m_flg;
  logic [4:0] m_ctl;

  function automatic logic [3:0] m_lvl();
    if (m_ctl[4]) return {m_ctl[3], m_ctl[2], m_ctl[0], m_ctl[1]};
    return m_d2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_d1 <= 4'h0; m_d2 <= 4'h0; m_prev <= 4'h0; m_flg <= 4'h0; m_ctl <= 5'h0;
    end else begin
      m_d1   <= ~pin_n;
      m_d2   <= m_d1;
      m_prev <= m_lvl();
      m_flg  <= (m_flg & ~((wr && addr == 3'd6) ? wdata[3:0] : 4'h0)) | (m_lvl() ^ m_prev);
      if (wr && addr == 3'd4) m_ctl <= wdata[4:0];
    end
  end

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    if (a == 3'd4) return {3'b000, m_ctl};
    if (a == 3'd6) return {m_lvl(), m_flg};
    return 8'h00;
  endfunction

  function automatic logic [3:0] exp_pins();
    if (m_ctl[4]) return 4'hf;
    return ~m_ctl[3:0];   // {out2,out1,rts,dtr}
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all();
    string t;
    if (addr == 3'd4) t = "R2";
    else if (addr == 3'd6) t = m_ctl[4] ? "R9 R5" : "R4 R5";
    else t = "R10";
    chk(t, rdata, exp_rd(addr));
    chk(m_ctl[4] ? "R9 pins" : "R3 pins", {o2_n, o1_n, rts_n, dtr_n}, exp_pins());
    chk("R8 irq", irq, msi_en & (|m_flg));
  endtask

  task automatic step(input logic [3:0] p, input logic w, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    pin_n = p; wr = w; addr = a; wdata = d;
    #1 check_all();
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    msi_en = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    addr = 3'd4; #1 chk("R1 ctl", rdata, 8'h00);
    addr = 3'd6; #1 chk("R1 sts", rdata, 8'h00);
    chk("R1 pins", {o2_n, o1_n, rts_n, dtr_n}, 4'hf);
    chk("R1 irq", irq, 1'b0);
    @(negedge clk) rst_n = 1'b1;

    // R2 upper bits read 0, R3 pins follow
    step(4'hf, 1'b1, 3'd4, 8'he5);
    step(4'hf, 1'b0, 3'd4, 8'h00);
    chk("R2 readback", rdata, 8'h05);
    chk("R3 dtr", dtr_n, 1'b0);
    step(4'hf, 1'b1, 3'd4, 8'h00);

    // R7: clear lands on the same edge as a CTS change
    step(4'hf, 1'b0, 3'd6, 8'h00);
    step(4'he, 1'b0, 3'd6, 8'h00);
    step(4'he, 1'b0, 3'd6, 8'h00);
    step(4'he, 1'b1, 3'd6, 8'h01);
    step(4'he, 1'b0, 3'd6, 8'h00);
    chk("R7 flag kept", rdata[0], 1'b1);
    chk("R4 cts level", rdata[4], 1'b1);
    // R6: clear with no change, other flags and levels untouched
    step(4'h6, 1'b0, 3'd6, 8'h00);
    repeat (3) step(4'h6, 1'b0, 3'd6, 8'h00);
    step(4'h6, 1'b1, 3'd6, 8'hf1);
    step(4'h6, 1'b0, 3'd6, 8'h00);
    chk("R6 partial clear", rdata, 8'h98);
    step(4'h6, 1'b1, 3'd6, 8'h0f);
    step(4'h6, 1'b0, 3'd6, 8'h00);
    chk("R6 full clear", rdata, 8'h90);
    chk("R8 irq low", irq, 1'b0);

    // R9: loopback with all control bits set
    step(4'h6, 1'b1, 3'd4, 8'h1f);
    step(4'h0, 1'b0, 3'd6, 8'h00);
    chk("R9 loop levels", rdata[7:4], 4'hf);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] p;
      logic [2:0] a;
      logic       w;
      int unsigned r;
      p = ($urandom % 4 == 0) ? 4'($urandom) : pin_n;
      r = $urandom % 8;
      a = (r < 3) ? 3'd6 : (r < 6) ? 3'd4 : 3'($urandom);
      w = ($urandom % 5 == 0);
      if ($urandom % 16 == 0) msi_en = ~msi_en;
      step(p, w, a, 8'($urandom));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule